// File: doc/BRIEF.md
# Two-Client Lock Arbiter

This block lets two clients, called left and right, share one exclusive resource through a single lock. On every clock edge it samples a two-bit request code from each client and produces a registered two-bit response code for each. The lock is in one of three states: free, owned by left, or owned by right.

When the lock is free, a lock request wins it, and left is preferred if both clients ask in the same cycle. The owner sees a grant response on every cycle until it releases. A release gets exactly one acknowledge cycle and returns the lock to free. Requests from the client that does not own the lock have no effect. Responses are flops, so the answer to the inputs sampled at an edge appears just after that edge.

Top module: `dual_lock_arbiter`

## Requirements
- R1: While reset is asserted and right after it is released, the lock is free and both response outputs read 00 (null).
- R2: Request codes are 00 null, 01 lock, 10 release. Response codes are 00 null, 01 grant, 10 acknowledge. A request of 11 acts as null, and no response output is ever 11.
- R3: From free, a left lock request moves the lock to left ownership and answers grant to left and null to right.
- R4: From free, when both clients request the lock in the same cycle, left wins: left gets grant, right gets null, and the owner is left.
- R5: From free, when left is not requesting the lock and right is, the lock goes to right, with null to left and grant to right.
- R6: From free, when neither client requests the lock, the lock stays free and both responses are null. A release sent while the lock is free has no effect.
- R7: When left owns the lock, a left release frees it and answers acknowledge to left and null to right.
- R8: When left owns the lock and left does not release, left keeps the lock and receives grant while right receives null, whatever right sends.
- R9: When right owns the lock, a right release frees it and answers null to left and acknowledge to right.
- R10: When right owns the lock and right does not release, right keeps the lock and receives grant while left receives null, whatever left sends.
- R11: The response to the inputs sampled at an edge appears after that edge and lasts one cycle. An acknowledge never lasts two cycles in a row.
- R12: The two response outputs never both show grant in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| left_req | input | 2 | Request code from the left client |
| right_req | input | 2 | Request code from the right client |
| left_rsp | output | 2 | Registered response code to the left client |
| right_rsp | output | 2 | Registered response code to the right client |

## Verification
The code width is fixed at two bits and the block has no other size, so the bench builds the design at its single configuration. At that size the whole input space is small. The bench applies all sixteen request pairs, including the unused 11 code, from each of the three lock states, and it checks the cycle after each pair so that acknowledge pulses and ownership changes are also covered. A long walk driven by a shift register then chains transitions in orders the sweep does not reach. Ownership is inferred from the responses at the ports, compared against an arithmetic model kept in the bench.

// File: rtl/dual_lock_pkg.sv
package dual_lock_pkg;

    localparam int CODE_W = 2;

    localparam logic [CODE_W-1:0] CODE_NONE  = 2'b00;
    localparam logic [CODE_W-1:0] CODE_TAKE  = 2'b01;
    localparam logic [CODE_W-1:0] CODE_DROP  = 2'b10;

    typedef enum logic [1:0] {
        ASK_NONE = 2'd0,
        ASK_TAKE = 2'd1,
        ASK_DROP = 2'd2
    } ask_e;

    typedef enum logic [1:0] {
        ANS_NONE  = 2'd0,
        ANS_GRANT = 2'd1,
        ANS_ACK   = 2'd2
    } ans_e;

    typedef enum logic [1:0] {
        OWN_FREE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        ans_e   left_ans;
        ans_e   right_ans;
    } lock_regs_t;

endpackage

// File: rtl/dual_lock_decode.sv
module dual_lock_decode
    import dual_lock_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output ask_e              ask
);
    always_comb begin
        unique case (code)
            CODE_TAKE: ask = ASK_TAKE;
            CODE_DROP: ask = ASK_DROP;
            default:   ask = ASK_NONE;   // 00 and the unused 11
        endcase
    end
endmodule

// File: rtl/dual_lock_encode.sv
module dual_lock_encode
    import dual_lock_pkg::*;
(
    input  ans_e              ans,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        unique case (ans)
            ANS_GRANT: code = CODE_TAKE;
            ANS_ACK:   code = CODE_DROP;
            default:   code = CODE_NONE;
        endcase
    end
endmodule

// File: rtl/dual_lock_core.sv
module dual_lock_core
    import dual_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ask_e left_ask,
    input  ask_e right_ask,
    output ans_e left_ans,
    output ans_e right_ans
);
    lock_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.owner)
            OWN_FREE: begin
                if (left_ask == ASK_TAKE) begin
                    regs_d.owner     = OWN_LEFT;
                    regs_d.left_ans  = ANS_GRANT;
                    regs_d.right_ans = ANS_NONE;
                end else if (right_ask == ASK_TAKE) begin
                    regs_d.owner     = OWN_RIGHT;
                    regs_d.left_ans  = ANS_NONE;
                    regs_d.right_ans = ANS_GRANT;
                end else begin
                    regs_d.owner     = OWN_FREE;
                    regs_d.left_ans  = ANS_NONE;
                    regs_d.right_ans = ANS_NONE;
                end
            end
            OWN_LEFT: begin
                regs_d.right_ans = ANS_NONE;
                if (left_ask == ASK_DROP) begin
                    regs_d.owner    = OWN_FREE;
                    regs_d.left_ans = ANS_ACK;
                end else begin
                    regs_d.owner    = OWN_LEFT;
                    regs_d.left_ans = ANS_GRANT;
                end
            end
            OWN_RIGHT: begin
                regs_d.left_ans = ANS_NONE;
                if (right_ask == ASK_DROP) begin
                    regs_d.owner     = OWN_FREE;
                    regs_d.right_ans = ANS_ACK;
                end else begin
                    regs_d.owner     = OWN_RIGHT;
                    regs_d.right_ans = ANS_GRANT;
                end
            end
            default: begin
                regs_d.owner     = OWN_FREE;
                regs_d.left_ans  = ANS_NONE;
                regs_d.right_ans = ANS_NONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{owner: OWN_FREE, left_ans: ANS_NONE, right_ans: ANS_NONE};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign left_ans  = regs_q.left_ans;
    assign right_ans = regs_q.right_ans;

    // R4
    left_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.owner == OWN_FREE && left_ask == ASK_TAKE) |=> (left_ans == ANS_GRANT && right_ans == ANS_NONE));

    // R8
    left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_ans == ANS_GRANT && left_ask != ASK_DROP) |=> (left_ans == ANS_GRANT));

    // R10
    right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (right_ans == ANS_GRANT && right_ask != ASK_DROP) |=> (right_ans == ANS_GRANT));

    // R11
    left_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_ans == ANS_ACK) |=> (left_ans != ANS_ACK));

    // R11
    right_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (right_ans == ANS_ACK) |=> (right_ans != ANS_ACK));

    // R12
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_ans == ANS_GRANT && right_ans == ANS_GRANT));
endmodule

// File: rtl/dual_lock_arbiter.sv
module dual_lock_arbiter
    import dual_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] left_req,
    input  logic [CODE_W-1:0] right_req,
    output logic [CODE_W-1:0] left_rsp,
    output logic [CODE_W-1:0] right_rsp
);
    localparam int PORTS = 2;

    logic [CODE_W-1:0] req_code [PORTS];
    logic [CODE_W-1:0] rsp_code [PORTS];
    ask_e              ask      [PORTS];
    ans_e              ans      [PORTS];

    assign req_code[0] = left_req;
    assign req_code[1] = right_req;

    for (genvar gi = 0; gi < PORTS; gi++) begin : g_port
        dual_lock_decode u_dec (.code(req_code[gi]), .ask(ask[gi]));
        dual_lock_encode u_enc (.ans(ans[gi]),       .code(rsp_code[gi]));
    end

    dual_lock_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .left_ask  (ask[0]),
        .right_ask (ask[1]),
        .left_ans  (ans[0]),
        .right_ans (ans[1])
    );

    assign left_rsp  = rsp_code[0];
    assign right_rsp = rsp_code[1];

    // R2
    no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_rsp != 2'b11 && right_rsp != 2'b11));

    // R6
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_rsp != CODE_TAKE && right_rsp != CODE_TAKE && left_req != CODE_TAKE && right_req != CODE_TAKE)
        |=> (left_rsp == CODE_NONE && right_rsp == CODE_NONE));
endmodule

// File: tb/dual_lock_arbiter_bench.sv
module dual_lock_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] left_req = 2'b00;
    logic [1:0] right_req = 2'b00;
    logic [1:0] left_rsp, right_rsp;

    int compared = 0;
    int mismatched = 0;
    int mstate = 0;   // 0 free, 1 left owns, 2 right owns

    always #4 clk = ~clk;

    dual_lock_arbiter u_dual_lock_arbiter (
        .clk(clk), .rst_n(rst_n),
        .left_req(left_req), .right_req(right_req),
        .left_rsp(left_rsp), .right_rsp(right_rsp)
    );

    task automatic check2(input string tag, input logic [1:0] al, ar, el, er);
        compared++;
        if (al !== el || ar !== er) begin
            mismatched++;
            $display("FAIL %s: left/right = %0d/%0d expected %0d/%0d", tag, al, ar, el, er);
        end
    endtask

    function automatic string tag_of(input int s, input logic [1:0] l, r);
        if (l == 2'b11 || r == 2'b11) return "R2";
        if (s == 0) begin
            if (l == 2'b01) return (r == 2'b01) ? "R4" : "R3";
            if (r == 2'b01) return "R5";
            return "R6";
        end
        if (s == 1) return (l == 2'b10) ? "R7" : "R8";
        return (r == 2'b10) ? "R9" : "R10";
    endfunction

    // Apply one request pair, compare after the edge, advance the model.
    task automatic step(input logic [1:0] l, r);
        logic [1:0] el, er;
        int ns;
        @(negedge clk);
        left_req = l; right_req = r;
        @(posedge clk); #1;
        el = 2'b00; er = 2'b00; ns = mstate;
        if (mstate == 0) begin
            if (l == 2'b01) begin ns = 1; el = 2'b01; end
            else if (r == 2'b01) begin ns = 2; er = 2'b01; end
        end else if (mstate == 1) begin
            if (l == 2'b10) begin ns = 0; el = 2'b10; end else el = 2'b01;
        end else begin
            if (r == 2'b10) begin ns = 0; er = 2'b10; end else er = 2'b01;
        end
        check2(tag_of(mstate, l, r), left_rsp, right_rsp, el, er);
        // R12 and R2: never two grants, never code 11
        compared++;
        if ((left_rsp == 2'b01 && right_rsp == 2'b01) || left_rsp == 2'b11 || right_rsp == 2'b11) begin
            mismatched++;
            $display("FAIL R12: left/right = %0d/%0d expected one owner, no 11", left_rsp, right_rsp);
        end
        mstate = ns;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; left_req = 2'b00; right_req = 2'b00;
        repeat (2) @(negedge clk);
        check2("R1", left_rsp, right_rsp, 2'b00, 2'b00);
        rst_n = 1'b1;
        #1;
        check2("R1", left_rsp, right_rsp, 2'b00, 2'b00);
        mstate = 0;
    endtask

    initial begin : watchdog
        #1000000;
        mismatched++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        do_reset();
        // Exhaustive sweep: every start state, every request pair, then a follow-up cycle.
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 16; p++) begin
                do_reset();
                if (s == 1) step(2'b01, 2'b00);
                if (s == 2) step(2'b00, 2'b01);
                step(p[3:2], p[1:0]);
                // R11: next cycle with idle inputs; an acknowledge must not persist
                step(2'b00, 2'b00);
            end
        end
        // Chained walk from a 16-bit shift register.
        do_reset();
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:2], lfsr[1:0]);
        end
        // Reset taken while the lock is owned must free it (R1).
        step(2'b00, 2'b01);
        do_reset();
        step(2'b00, 2'b00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule